// File: doc/BRIEF.md
# Host Parallel Memory Access Port

This block lets an external host processor read and write the on-chip program and data memories of a signal-processing core. It has an asynchronous host side and a synchronous core side. On the host side there is a 16-bit multiplexed address/data bus and four control strobes: an active-low select, an address-latch pulse, an active-low read and an active-low write. It also drives an acknowledge output. The strobes are passed through two-flop synchronisers, and every action starts on a synchronised strobe edge.

A session opens with one latch cycle. That cycle loads either a starting location or an overlay selection, chosen by the top bus bit. A run of data transfers follows, and the location advances on its own after each completed word. Data memory words are 16 bits and move in one transfer. Program memory words are 24 bits and move in two transfers. On the core side the port raises a request to the memory arbiter and holds it until the arbiter grants a cycle. Each access the host makes therefore steals one core memory cycle.

Top module: `hpa_port`

## Requirements
- R1: A latch event is a falling edge of `host_ale` while `host_sel_n` is low. On a latch event with bus bit 15 = 0, bits 13:0 become the current location and bit 14 selects the space (0 program, 1 data). This also restarts the program-word half sequence at the upper half.
- R2: On a latch event with bit 15 = 1 and bits 14:8 all zero, bits 7:0 appear on `ovl_sel`. The current location is left unchanged.
- R3: An overlay latch with any of bits 14:8 set is ignored, and `ovl_sel` keeps its value.
- R4: After each completed word the location advances by one and wraps from 16383 to 0 within the same space.
- R5: A program-memory write takes two host writes. The first supplies bits 23:8. The second supplies bits 7:0 in its low byte, issues one memory write of the full 24-bit word, and advances the location.
- R6: A program-memory read takes two host reads. The first returns word bits 23:8. The second returns {8'h00, word bits 7:0} without a new memory access, then the location advances.
- R7: A data-memory access moves one 16-bit word per host transfer. Writes present `mem_wdata` with bits 23:16 zero, and reads return `mem_rdata` bits 15:0.
- R8: Host writes to data addresses 16352 to 16383 (the top 32 locations) raise no memory request. The location still advances past them.
- R9: `host_ack` goes low on the third core clock edge after a read, write or latch strobe falls. For a memory access, `mem_req` rises on that same edge and stays high, with a stable address, until `mem_gnt`.
- R10: `host_ack` stays low while the grant is withheld and rises on the clock edge that follows the granted cycle. Transfers that do not touch memory hold it low for exactly one cycle.
- R11: After reset, `host_ack` is 1, `mem_req` is 0, `ovl_sel` is 0, and the location is program address 0, upper half.
- R12: `host_ad_oe` is 1 exactly when `host_sel_n` and `host_rd_n` are both low. A read strobe with select high produces no transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| host_sel_n | input | 1 | Host select, active low |
| host_ale | input | 1 | Address-latch pulse; acts on its falling edge |
| host_rd_n | input | 1 | Host read strobe, active low |
| host_wr_n | input | 1 | Host write strobe, active low |
| host_ad_in | input | 16 | Multiplexed address/data from host |
| host_ad_out | output | 16 | Read data to host |
| host_ad_oe | output | 1 | Bus drive enable toward host |
| host_ack | output | 1 | High = ready for next cycle, low = busy |
| ovl_sel | output | 8 | Latched overlay selection |
| mem_req | output | 1 | Memory cycle request to core arbiter |
| mem_gnt | input | 1 | Grant; the access happens on the edge where req and gnt are both high |
| mem_we | output | 1 | Request is a write |
| mem_dm | output | 1 | Request targets data memory (else program memory) |
| mem_addr | output | 14 | Memory word address |
| mem_wdata | output | 24 | Write data |
| mem_rdata | input | 24 | Read data, sampled at the granted edge |

## Verification
The assertions check four things on every cycle: a pending request holds its address until granted, the acknowledge is low whenever a request is pending, no write ever reaches the protected top of data memory, and the overlay register changes only right after a latch event. The location advancing on each step is also checked every cycle. Only the bench scenarios can show the effects that depend on the whole data path. Those are the half ordering of 24-bit words, read data matching earlier writes, a dropped protected write being skipped over, wrap-around, overlay rejection, and the exact acknowledge latency with and without stolen-cycle contention.

// File: rtl/hpa_pkg.sv
package hpa_pkg;

    localparam int HPA_BUS_W  = 16;
    localparam int HPA_ADDR_W = 14;
    localparam int HPA_PM_W   = 24;
    localparam int HPA_OVL_W  = 8;
    localparam int HPA_LO_W   = HPA_PM_W - HPA_BUS_W;

    // strobe vector bit positions after synchronisation
    localparam int STB_SEL = 0;
    localparam int STB_ALE = 1;
    localparam int STB_RD  = 2;
    localparam int STB_WR  = 3;
    localparam int STB_N   = 4;

    typedef enum logic [1:0] {
        XF_IDLE = 2'd0,
        XF_ACC  = 2'd1,
        XF_FIN  = 2'd2
    } xf_state_e;

    typedef struct packed {
        logic                  dm;
        logic [HPA_ADDR_W-1:0] addr;
    } mem_loc_t;

    typedef struct packed {
        logic                 load_loc;
        logic                 load_ovl;
        mem_loc_t             loc;
        logic [HPA_OVL_W-1:0] ovl;
    } latch_cmd_t;

    function automatic latch_cmd_t decode_latch(input logic [HPA_BUS_W-1:0] w);
        latch_cmd_t c;
        c.load_loc = ~w[HPA_BUS_W-1];
        c.load_ovl = w[HPA_BUS_W-1] && (w[HPA_BUS_W-2:HPA_OVL_W] == '0);
        c.loc.dm   = w[HPA_BUS_W-2];
        c.loc.addr = w[HPA_ADDR_W-1:0];
        c.ovl      = w[HPA_OVL_W-1:0];
        return c;
    endfunction

    function automatic logic in_ctrl_span(input mem_loc_t l, input int span);
        logic [HPA_ADDR_W:0] lim;
        lim = (HPA_ADDR_W+1)'((1 << HPA_ADDR_W) - span);
        return l.dm && ({1'b0, l.addr} >= lim);
    endfunction

endpackage

// File: rtl/hpa_sync.sv
module hpa_sync #(
    parameter int             N       = 4,
    parameter int             STAGES  = 2,
    parameter logic [N-1:0]   RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] d,
    output logic [N-1:0] q,
    output logic [N-1:0] fell
);

    logic [N-1:0] q_prev;

    for (genvar i = 0; i < N; i++) begin : g_bit
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) chain <= {STAGES{RST_VAL[i]}};
            else     chain <= {chain[STAGES-2:0], d[i]};
        end
        assign q[i] = chain[STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (rst) q_prev <= RST_VAL;
        else     q_prev <= q;
    end

    assign fell = q_prev & ~q;

endmodule

// File: rtl/hpa_addr_reg.sv
module hpa_addr_reg
    import hpa_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 lat_ev,
    input  logic [HPA_BUS_W-1:0] bus,
    input  logic                 step_i,
    output mem_loc_t             loc_o,
    output logic [HPA_OVL_W-1:0] ovl_o,
    output logic                 loc_load_o
);

    latch_cmd_t cmd;
    mem_loc_t   loc_q;
    logic [HPA_OVL_W-1:0] ovl_q;

    assign cmd        = decode_latch(bus);
    assign loc_load_o = lat_ev && cmd.load_loc;

    always_ff @(posedge clk) begin
        if (rst) begin
            loc_q <= '0;
        end else if (loc_load_o) begin
            loc_q <= cmd.loc;
        end else if (step_i) begin
            loc_q.addr <= loc_q.addr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                         ovl_q <= '0;
        else if (lat_ev && cmd.load_ovl) ovl_q <= cmd.ovl;
    end

    assign loc_o = loc_q;
    assign ovl_o = ovl_q;

    // R4: a step with no concurrent reload moves the location forward by one
    assert_addr_step_R4: assert property (@(posedge clk) disable iff (rst)
        (step_i && !lat_ev) |=> (loc_q.addr == HPA_ADDR_W'($past(loc_q.addr) + 1'b1)));

    // R4: the space bit never changes except through a latch
    assert_space_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !lat_ev |=> $stable(loc_q.dm));

endmodule

// File: rtl/hpa_xfer_ctl.sv
module hpa_xfer_ctl
    import hpa_pkg::*;
#(
    parameter int CTRL_SPAN = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 lat_ev,
    input  logic                 loc_load,
    input  logic                 rd_ev,
    input  logic                 wr_ev,
    input  logic [HPA_BUS_W-1:0] din,
    input  mem_loc_t             loc,
    input  logic                 mem_gnt,
    input  logic [HPA_PM_W-1:0]  mem_rdata,
    output logic                 mem_req,
    output logic                 mem_we,
    output logic [HPA_PM_W-1:0]  mem_wdata,
    output logic                 step_o,
    output logic [HPA_BUS_W-1:0] dout,
    output logic                 busy
);

    xf_state_e             st_q, st_d;
    logic                  ph_q, ph_d;      // 0: upper half next, 1: low byte next
    logic [HPA_BUS_W-1:0]  hi_q, hi_d;
    logic [HPA_LO_W-1:0]   lo_q, lo_d;
    logic [HPA_PM_W-1:0]   wd_q, wd_d;
    logic                  we_q, we_d;
    logic [HPA_BUS_W-1:0]  do_q, do_d;
    logic                  step;

    always_comb begin
        st_d = st_q;
        ph_d = ph_q;
        hi_d = hi_q;
        lo_d = lo_q;
        wd_d = wd_q;
        we_d = we_q;
        do_d = do_q;
        step = 1'b0;
        unique case (st_q)
            XF_IDLE: begin
                if (lat_ev) begin
                    st_d = XF_FIN;
                    if (loc_load) ph_d = 1'b0;
                end else if (wr_ev) begin
                    if (loc.dm) begin
                        if (in_ctrl_span(loc, CTRL_SPAN)) begin
                            st_d = XF_FIN;
                            step = 1'b1;
                        end else begin
                            wd_d = {{HPA_LO_W{1'b0}}, din};
                            we_d = 1'b1;
                            st_d = XF_ACC;
                        end
                    end else if (!ph_q) begin
                        hi_d = din;
                        ph_d = 1'b1;
                        st_d = XF_FIN;
                    end else begin
                        wd_d = {hi_q, din[HPA_LO_W-1:0]};
                        we_d = 1'b1;
                        st_d = XF_ACC;
                    end
                end else if (rd_ev) begin
                    if (!loc.dm && ph_q) begin
                        do_d = {{(HPA_BUS_W-HPA_LO_W){1'b0}}, lo_q};
                        ph_d = 1'b0;
                        step = 1'b1;
                        st_d = XF_FIN;
                    end else begin
                        we_d = 1'b0;
                        st_d = XF_ACC;
                    end
                end
            end
            XF_ACC: begin
                if (mem_gnt) begin
                    st_d = XF_IDLE;
                    if (we_q) begin
                        step = 1'b1;
                        ph_d = 1'b0;
                    end else if (loc.dm) begin
                        do_d = mem_rdata[HPA_BUS_W-1:0];
                        step = 1'b1;
                    end else begin
                        do_d = mem_rdata[HPA_PM_W-1:HPA_LO_W];
                        lo_d = mem_rdata[HPA_LO_W-1:0];
                        ph_d = 1'b1;
                    end
                end
            end
            XF_FIN:  st_d = XF_IDLE;
            default: st_d = XF_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= XF_IDLE;
            ph_q <= 1'b0;
            hi_q <= '0;
            lo_q <= '0;
            wd_q <= '0;
            we_q <= 1'b0;
            do_q <= '0;
        end else begin
            st_q <= st_d;
            ph_q <= ph_d;
            hi_q <= hi_d;
            lo_q <= lo_d;
            wd_q <= wd_d;
            we_q <= we_d;
            do_q <= do_d;
        end
    end

    assign mem_req   = (st_q == XF_ACC);
    assign mem_we    = we_q;
    assign mem_wdata = wd_q;
    assign step_o    = step;
    assign dout      = do_q;
    assign busy      = (st_q != XF_IDLE);

    // R9: a request waiting for grant keeps its data and direction
    assert_req_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_wdata) && $stable(mem_we)));

    // R10: the busy phase after a non-memory transfer lasts one cycle
    assert_fin_one_R10: assert property (@(posedge clk) disable iff (rst)
        (busy && !mem_req) |=> !busy);

endmodule

// File: rtl/hpa_port.sv
module hpa_port
    import hpa_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int CTRL_SPAN   = 32
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   host_sel_n,
    input  logic                   host_ale,
    input  logic                   host_rd_n,
    input  logic                   host_wr_n,
    input  logic [HPA_BUS_W-1:0]   host_ad_in,
    output logic [HPA_BUS_W-1:0]   host_ad_out,
    output logic                   host_ad_oe,
    output logic                   host_ack,
    output logic [HPA_OVL_W-1:0]   ovl_sel,
    output logic                   mem_req,
    input  logic                   mem_gnt,
    output logic                   mem_we,
    output logic                   mem_dm,
    output logic [HPA_ADDR_W-1:0]  mem_addr,
    output logic [HPA_PM_W-1:0]    mem_wdata,
    input  logic [HPA_PM_W-1:0]    mem_rdata
);

    logic [STB_N-1:0] stb_raw, stb_q, stb_fell;
    logic lat_ev, rd_ev, wr_ev, sel_on;
    logic loc_load, step, busy;
    logic unused_sel_fall;
    mem_loc_t loc;

    assign stb_raw[STB_SEL] = host_sel_n;
    assign stb_raw[STB_ALE] = host_ale;
    assign stb_raw[STB_RD]  = host_rd_n;
    assign stb_raw[STB_WR]  = host_wr_n;

    hpa_sync #(
        .N       (STB_N),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (4'b1101)
    ) u_sync (
        .clk  (clk),
        .rst  (rst),
        .d    (stb_raw),
        .q    (stb_q),
        .fell (stb_fell)
    );

    assign unused_sel_fall = stb_fell[STB_SEL];
    assign sel_on = ~stb_q[STB_SEL];
    assign lat_ev = sel_on && stb_fell[STB_ALE] && stb_q[STB_RD] && stb_q[STB_WR];
    assign wr_ev  = sel_on && stb_fell[STB_WR] && stb_q[STB_RD] && !stb_q[STB_ALE];
    assign rd_ev  = sel_on && stb_fell[STB_RD] && stb_q[STB_WR] && !stb_q[STB_ALE];

    hpa_addr_reg u_addr (
        .clk        (clk),
        .rst        (rst),
        .lat_ev     (lat_ev),
        .bus        (host_ad_in),
        .step_i     (step),
        .loc_o      (loc),
        .ovl_o      (ovl_sel),
        .loc_load_o (loc_load)
    );

    hpa_xfer_ctl #(
        .CTRL_SPAN (CTRL_SPAN)
    ) u_ctl (
        .clk       (clk),
        .rst       (rst),
        .lat_ev    (lat_ev),
        .loc_load  (loc_load),
        .rd_ev     (rd_ev),
        .wr_ev     (wr_ev),
        .din       (host_ad_in),
        .loc       (loc),
        .mem_gnt   (mem_gnt),
        .mem_rdata (mem_rdata),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_wdata (mem_wdata),
        .step_o    (step),
        .dout      (host_ad_out),
        .busy      (busy)
    );

    assign mem_dm     = loc.dm;
    assign mem_addr   = loc.addr;
    assign host_ack   = ~busy;
    assign host_ad_oe = ~host_sel_n & ~host_rd_n;

    // R10: acknowledge reports busy whenever a request is pending
    assert_busy_on_req_R10: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> !host_ack);

    // R8: no write request ever targets the protected data span
    assert_no_ctrl_write_R8: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |-> !in_ctrl_span(loc, CTRL_SPAN));

    // R9: the location presented to memory is frozen until grant
    assert_addr_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_gnt) |=> ($stable(mem_addr) && $stable(mem_dm)));

    // R3: the overlay output moves only in the cycle after a latch event
    assert_ovl_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !lat_ev |=> $stable(ovl_sel));

endmodule

// File: tb/hpa_port_tb.sv
module hpa_port_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 16384;
    localparam int SPAN       = 32;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_sel_n = 1'b1, host_ale = 1'b0, host_rd_n = 1'b1, host_wr_n = 1'b1;
    logic [15:0] host_ad_in = '0;
    logic [15:0] host_ad_out;
    logic        host_ad_oe, host_ack, mem_req, mem_gnt, mem_we, mem_dm;
    logic [7:0]  ovl_sel;
    logic [13:0] mem_addr;
    logic [23:0] mem_wdata;
    logic [23:0] mem_rdata = '0;
    logic        hold_forced = 1'b0, hold_rand = 1'b0, steal_en = 1'b0;

    int n_chk = 0, n_fail = 0;

    logic [23:0] pm_m [int];
    logic [23:0] dm_m [int];
    logic [23:0] exp_pm [int];
    logic [23:0] exp_dm [int];
    logic        exp_sp = 1'b0, exp_ph = 1'b0;
    int          exp_addr = 0;
    logic [15:0] exp_hi = '0;
    logic [7:0]  exp_ovl = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hpa_port dut_i (
        .clk(clk), .rst(rst), .host_sel_n(host_sel_n), .host_ale(host_ale),
        .host_rd_n(host_rd_n), .host_wr_n(host_wr_n), .host_ad_in(host_ad_in),
        .host_ad_out(host_ad_out), .host_ad_oe(host_ad_oe), .host_ack(host_ack),
        .ovl_sel(ovl_sel), .mem_req(mem_req), .mem_gnt(mem_gnt), .mem_we(mem_we),
        .mem_dm(mem_dm), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // memory arrays and arbiter on the core side
    assign mem_gnt = mem_req && !(hold_forced || hold_rand);

    always @(posedge clk) begin
        if (mem_req && mem_gnt && mem_we) begin
            if (mem_dm) dm_m[int'(mem_addr)] = mem_wdata;
            else        pm_m[int'(mem_addr)] = mem_wdata;
        end
    end

    always @(negedge clk) begin
        if (mem_dm) mem_rdata <= dm_m.exists(int'(mem_addr)) ? dm_m[int'(mem_addr)] : 24'h0;
        else        mem_rdata <= pm_m.exists(int'(mem_addr)) ? pm_m[int'(mem_addr)] : 24'h0;
        hold_rand <= steal_en && ($urandom_range(0, 2) == 0);
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [23:0] exp_word(input logic sp, input int a);
        if (sp) return exp_dm.exists(a) ? exp_dm[a] : 24'h0;
        return exp_pm.exists(a) ? exp_pm[a] : 24'h0;
    endfunction

    // kind: 0 latch, 1 write, 2 read
    task automatic host_op(input int kind, input logic [15:0] din, input int hold,
                           output logic [15:0] dout, output int t_low, output int t_high);
        @(negedge clk);
        host_sel_n = 1'b0;
        host_ad_in = din;
        hold_forced = (hold > 0);
        @(negedge clk);
        if (kind == 0) begin
            host_ale = 1'b1;
            @(negedge clk);
            host_ale = 1'b0;
        end else if (kind == 1) host_wr_n = 1'b0;
        else                    host_rd_n = 1'b0;
        t_low = 0;
        do begin
            @(negedge clk);
            t_low++;
        end while (host_ack && t_low < 50);
        if (t_low >= 50) chk(1'b0, "R9 ack never dropped", 32'(host_ack), 32'd0);
        for (int h = 0; h < hold; h++) begin
            @(negedge clk);
            chk(!host_ack && mem_req, "R10 busy while grant withheld", {host_ack, mem_req}, 32'b01);
        end
        hold_forced = 1'b0;
        t_high = 0;
        while (!host_ack && t_high < 50) begin
            @(negedge clk);
            t_high++;
        end
        if (t_high >= 50) chk(1'b0, "R10 ack never returned", 32'(host_ack), 32'd1);
        dout = host_ad_out;
        if (kind == 2) chk(host_ad_oe == 1'b1, "R12 drive during read", 32'(host_ad_oe), 32'd1);
        host_rd_n = 1'b1;
        host_wr_n = 1'b1;
        @(negedge clk);
        host_sel_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic latch_loc(input logic sp, input logic [13:0] a);
        logic [15:0] d; int tl, th;
        host_op(0, {1'b0, sp, a}, 0, d, tl, th);
        exp_sp = sp; exp_addr = int'(a); exp_ph = 1'b0;
    endtask

    task automatic latch_raw(input logic [15:0] w, input string tag);
        logic [15:0] d; int tl, th;
        host_op(0, w, 0, d, tl, th);
        if (w[14:8] == 7'd0) exp_ovl = w[7:0];
        chk(ovl_sel == exp_ovl, tag, 32'(ovl_sel), 32'(exp_ovl));
    endtask

    task automatic wr(input logic [15:0] d, input int hold, output int tl, output int th);
        logic [15:0] q;
        host_op(1, d, hold, q, tl, th);
        if (exp_sp) begin
            if (exp_addr < DEPTH - SPAN) exp_dm[exp_addr] = {8'h00, d};
            exp_addr = (exp_addr + 1) % DEPTH;
        end else if (!exp_ph) begin
            exp_hi = d; exp_ph = 1'b1;
        end else begin
            exp_pm[exp_addr] = {exp_hi, d[7:0]};
            exp_addr = (exp_addr + 1) % DEPTH;
            exp_ph = 1'b0;
        end
    endtask

    task automatic wr0(input logic [15:0] d);
        int tl, th;
        wr(d, 0, tl, th);
    endtask

    task automatic rd_chk(input string tag, input int hold);
        logic [15:0] got, e; logic [23:0] w; int tl, th;
        w = exp_word(exp_sp, exp_addr);
        if (exp_sp)       e = w[15:0];
        else if (!exp_ph) e = w[23:8];
        else              e = {8'h00, w[7:0]};
        host_op(2, 16'h0, hold, got, tl, th);
        chk(got == e, tag, 32'(got), 32'(e));
        if (exp_sp) exp_addr = (exp_addr + 1) % DEPTH;
        else if (!exp_ph) exp_ph = 1'b1;
        else begin exp_ph = 1'b0; exp_addr = (exp_addr + 1) % DEPTH; end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL R10 watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : main
        int tl, th, bad;
        logic [15:0] q;
        void'($urandom(32'd2024));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        chk(host_ack == 1'b1, "R11 ack after reset", 32'(host_ack), 32'd1);
        chk(mem_req == 1'b0, "R11 no request after reset", 32'(mem_req), 32'd0);
        chk(ovl_sel == 8'h00, "R11 overlay after reset", 32'(ovl_sel), 32'd0);
        chk(host_ad_oe == 1'b0, "R11 bus idle after reset", 32'(host_ad_oe), 32'd0);
        // R11 default location is program 0, upper half
        wr0(16'h1234); wr0(16'hAB56);
        chk(pm_m.exists(0) && pm_m[0] == 24'h123456, "R11 R5 default location word",
            pm_m.exists(0) ? 32'(pm_m[0]) : 32'hdead, 32'h123456);

        // R12 read strobe with select high: no drive, no transfer
        @(negedge clk); host_rd_n = 1'b0;
        repeat (5) @(negedge clk);
        chk(host_ad_oe == 1'b0, "R12 no drive without select", 32'(host_ad_oe), 32'd0);
        chk(host_ack == 1'b1 && mem_req == 1'b0, "R12 no transfer without select",
            {host_ack, mem_req}, 32'b10);
        host_rd_n = 1'b1;
        repeat (4) @(negedge clk);

        // R9 R10 latency, uncontended data write
        latch_loc(1'b1, 14'd5);
        wr(16'hC0DE, 0, tl, th);
        chk(tl == 3, "R9 ack fall latency", 32'(tl), 32'd3);
        chk(th == 1, "R10 ack return latency", 32'(th), 32'd1);
        chk(dm_m.exists(5) && dm_m[5] == 24'h00C0DE, "R7 data word with zero top byte",
            dm_m.exists(5) ? 32'(dm_m[5]) : 32'hdead, 32'h00C0DE);
        // R10 grant withheld for four cycles
        wr(16'h7777, 4, tl, th);
        chk(th == 1, "R10 ack after late grant", 32'(th), 32'd1);
        latch_loc(1'b1, 14'd5);
        rd_chk("R7 R4 read back first", 3);
        rd_chk("R7 R4 read back second", 0);

        // R2 R3 overlay latches
        latch_loc(1'b1, 14'd100);
        wr0(16'h1111);
        latch_raw(16'h80A5, "R2 overlay loaded");
        latch_raw(16'h8233, "R3 overlay with nonzero field ignored");
        latch_raw(16'hC001, "R3 overlay with bit 14 ignored");
        wr0(16'h2222);
        latch_loc(1'b1, 14'd100);
        rd_chk("R2 location kept across overlay latch", 0);
        rd_chk("R2 R4 next location", 0);

        // R1 latch restarts the program-word half order
        latch_loc(1'b0, 14'd200);
        wr0(16'hDEAD);
        latch_loc(1'b0, 14'd210);
        wr0(16'h4455); wr0(16'h0066);
        latch_loc(1'b0, 14'd210);
        rd_chk("R6 upper half", 0);
        rd_chk("R6 low byte", 0);
        latch_loc(1'b0, 14'd200);
        rd_chk("R1 abandoned half left memory unchanged", 0);

        // R8 protected span and R4 wrap
        latch_loc(1'b1, 14'd16351);
        wr0(16'hAAAA); wr0(16'hBBBB); wr0(16'hCCCC);
        latch_loc(1'b1, 14'd16383);
        wr0(16'hDDDD); wr0(16'hEEEE);
        latch_loc(1'b1, 14'd16351);
        rd_chk("R8 last writable word", 0);
        rd_chk("R8 protected word dropped", 0);
        latch_loc(1'b1, 14'd0);
        rd_chk("R4 R8 wrap after dropped write", 0);
        latch_loc(1'b0, 14'd16383);
        wr0(16'h0102); wr0(16'h0003); wr0(16'h0405); wr0(16'h0006);
        latch_loc(1'b0, 14'd0);
        rd_chk("R4 program wrap upper", 0);
        rd_chk("R4 program wrap low", 0);

        // random sessions with cycle stealing
        steal_en = 1'b1;
        for (int it = 0; it < 30; it++) begin
            automatic int   n  = $urandom_range(1, 4);
            automatic int   a  = $urandom_range(300, 16000);
            automatic logic sp = 1'($urandom_range(0, 1));
            latch_loc(sp, 14'(a));
            for (int k = 0; k < n; k++) begin
                wr0(16'($urandom));
                if (!sp) wr0(16'($urandom));
            end
            latch_loc(sp, 14'(a));
            for (int k = 0; k < n; k++) begin
                if (sp) rd_chk("R7 random data read", 0);
                else begin
                    rd_chk("R6 random program upper", 0);
                    rd_chk("R6 random program low", 0);
                end
            end
        end
        steal_en = 1'b0;

        // memory contents against the model
        bad = 0;
        foreach (exp_pm[k]) if (!pm_m.exists(k) || pm_m[k] != exp_pm[k]) bad++;
        chk(bad == 0, "R5 program memory contents", 32'(bad), 32'd0);
        bad = 0;
        foreach (exp_dm[k]) if (!dm_m.exists(k) || dm_m[k] != exp_dm[k]) bad++;
        chk(bad == 0, "R7 data memory contents", 32'(bad), 32'd0);
        bad = 0;
        foreach (dm_m[k]) if (k >= DEPTH - SPAN) bad++;
        chk(bad == 0, "R8 no protected location written", 32'(bad), 32'd0);

        q = host_ad_out;
        chk(host_ack == 1'b1, "R10 idle at end", 32'(host_ack), 32'd1);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule